// File: doc/BRIEF.md
# Sequential-Read RAM Enable Controller

This block sits in front of a four-way set-associative cache and decides each cycle which tag RAMs and which data RAM halves are switched on. Every way stores a line of eight 32-bit words in two 32-bit RAMs. Even-numbered words go in one RAM and odd-numbered words in the other, so the pair gives a 64-bit read row. Power is saved in two ways. First, a read that stays in the line of the previous read, after that read hit, skips the tag RAMs and enables only the data RAM of the known way. Second, a 32-bit read enables only the bank that holds the addressed word.

A 64-bit read that starts on an odd word cannot be served by one row. The block splits it into two single-word accesses. While the first half runs, `req_ready` is low and the requester holds its request. In the following cycle the block performs the second half from its own stored address. `acc_addr` reports the address of the access that is running. The lookup result for a full lookup returns one cycle later on `hit_valid`/`hit_way`. The block uses it in that same cycle when the next read can reuse the way.

The history machine has three states. `H_NONE` means there is no usable history. `H_LOOK` means a full lookup ran in the previous cycle and its result is arriving now. `H_KNOWN` means a way is stored for the recorded line. The transitions are:
- Any cache-off, idle, write or maintenance cycle moves to `H_NONE`.
- A read that reuses a way moves to `H_KNOWN`.
- Any other read moves to `H_LOOK`.

The split machine has two states, `PH_FIRST` and `PH_SECOND`. It goes from `PH_FIRST` to `PH_SECOND` on an odd-start 64-bit read while the cache is on. It always returns from `PH_SECOND` to `PH_FIRST` after one cycle.

Top module: `seqrd_gate`

## Requirements
- R1: A read with no usable history enables all four tag RAMs and keeps `reuse_hit` low.
- R2: A read in the line of the previous read, where that read was a full lookup now reported as a hit (`hit_valid`=1), enables no tag RAM. It enables only the data RAM of way `hit_way` and raises `reuse_hit`.
- R3: Once a way is known, further reads in the same line keep reusing the stored way, and `hit_valid`/`hit_way` are ignored.
- R4: A read in a different line (byte address bits above bit 4 differ) performs a full lookup.
- R5: A full lookup reported as a miss (`hit_valid`=0) makes the next same-line read perform a full lookup.
- R6: An idle cycle, a write or a maintenance request clears the history. A write enables all tag RAMs and no data RAM. A maintenance request (priority over write) enables nothing.
- R7: On a 32-bit read, address bit 2 selects the bank: 0 enables only `data_en_even`, 1 enables only `data_en_odd`.
- R8: A 64-bit read with address bit 2 clear enables both banks and keeps `req_ready` high.
- R9: A 64-bit read with address bit 2 set first reads the odd bank with `req_ready` low. The next cycle reads the even bank at the next word address (`acc_addr`+4, word aligned) with `req_ready` high, and the request inputs of that cycle are ignored.
- R10: A split starting on word 7 runs its second half as a full lookup in the next line.
- R11: With `cache_on` low, nothing is enabled, `reuse_hit` is low, `req_ready` is high, no split starts and the history is cleared.
- R12: With no request, all enables and `reuse_hit` are low and `req_ready` is high. This includes the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cache_on | input | 1 | Cache enable |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | Request is a write |
| req_maint | input | 1 | Request is a maintenance operation |
| req_dword | input | 1 | 64-bit read (else 32-bit) |
| req_addr | input | ADDR_W | Byte address of the request |
| hit_valid | input | 1 | Previous-cycle lookup hit |
| hit_way | input | WAY_W | Way of that hit |
| req_ready | output | 1 | Request completes this cycle |
| acc_addr | output | ADDR_W | Address of the current access |
| tag_en | output | NUM_WAYS | Tag RAM enables per way |
| data_en_even | output | NUM_WAYS | Even-word data RAM enables per way |
| data_en_odd | output | NUM_WAYS | Odd-word data RAM enables per way |
| reuse_hit | output | 1 | Tag read skipped; the stored way is in use |

## Verification
The assertions assume that the requester holds its request unchanged while `req_ready` is low. They also assume that `hit_valid` carries a real result only in the cycle after a full lookup. The stimulus applies every change on the falling edge. It supplies hit information only in cycles where the history is `H_LOOK`, except where a requirement states that the information is ignored. In the cycle after a split starts, the bench deliberately drives unrelated inputs to show that the second half does not depend on them.

// File: rtl/seqrd_pkg.sv
package seqrd_pkg;
    typedef enum logic [1:0] {
        H_NONE  = 2'd0,
        H_LOOK  = 2'd1,
        H_KNOWN = 2'd2
    } hist_e;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_MAINT = 2'd3
    } op_e;
endpackage

// File: rtl/seqrd_split.sv
module seqrd_split
    import seqrd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_on,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_maint,
    input  logic              req_dword,
    input  logic [ADDR_W-1:0] req_addr,
    output op_e               cur_op,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cur_both,
    output logic              req_ready,
    output phase_e            phase
);
    localparam logic [ADDR_W-3:0] WORD_ONE = {{(ADDR_W-3){1'b0}}, 1'b1};

    phase_e            phase_q, phase_d;
    logic [ADDR_W-1:0] hold_q;
    op_e               in_op;
    logic              odd_dw;

    // Classify the incoming request; maintenance wins over write.
    always_comb begin
        if (!req_valid)     in_op = OP_IDLE;
        else if (req_maint) in_op = OP_MAINT;
        else if (req_write) in_op = OP_WRITE;
        else                in_op = OP_READ;
    end

    assign odd_dw = (in_op == OP_READ) && req_dword && req_addr[2];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_FIRST;
            hold_q  <= '0;
        end else begin
            phase_q <= phase_d;
            if (phase_q == PH_FIRST && odd_dw)
                hold_q <= {req_addr[ADDR_W-1:2] + WORD_ONE, 2'b00};
        end
    end

    // Next state and outputs
    always_comb begin
        phase_d   = PH_FIRST;
        cur_op    = OP_IDLE;
        cur_addr  = req_addr;
        cur_both  = 1'b0;
        req_ready = 1'b1;
        unique case (phase_q)
            PH_FIRST: begin
                cur_op    = in_op;
                cur_addr  = req_addr;
                cur_both  = (in_op == OP_READ) && req_dword && !req_addr[2];
                req_ready = !(cache_on && odd_dw);
                phase_d   = (cache_on && odd_dw) ? PH_SECOND : PH_FIRST;
            end
            PH_SECOND: begin
                cur_op    = OP_READ;
                cur_addr  = hold_q;
                cur_both  = 1'b0;
                req_ready = 1'b1;
                phase_d   = PH_FIRST;
            end
            default: phase_d = PH_FIRST;
        endcase
    end

    assign phase = phase_q;

    AST_SECOND_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SECOND) |=> (phase_q == PH_FIRST)); // R9

    AST_SPLIT_ONLY_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SECOND) |-> $past(cache_on)); // R11
endmodule

// File: rtl/seqrd_hist.sv
module seqrd_hist
    import seqrd_pkg::*;
#(
    parameter int LINE_W = 27,
    parameter int WAY_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_on,
    input  op_e               cur_op,
    input  logic [LINE_W-1:0] cur_line,
    input  logic              hit_valid,
    input  logic [WAY_W-1:0]  hit_way,
    output logic              seq_hit,
    output logic [WAY_W-1:0]  seq_way
);
    hist_e             hist_q, hist_d;
    logic [LINE_W-1:0] line_q;
    logic [WAY_W-1:0]  way_q;
    logic              same_line;

    assign same_line = (cur_line == line_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= H_NONE;
            line_q <= '0;
            way_q  <= '0;
        end else begin
            hist_q <= hist_d;
            if (cache_on && cur_op == OP_READ) begin
                line_q <= cur_line;
                if (seq_hit) way_q <= seq_way;
            end
        end
    end

    // Reuse decision and next state
    always_comb begin
        seq_hit = 1'b0;
        seq_way = way_q;
        unique case (hist_q)
            H_NONE: begin
                seq_hit = 1'b0;
            end
            H_LOOK: begin
                seq_hit = same_line && hit_valid;
                seq_way = hit_way;
            end
            H_KNOWN: begin
                seq_hit = same_line;
                seq_way = way_q;
            end
            default: seq_hit = 1'b0;
        endcase
        if (!cache_on || cur_op != OP_READ) seq_hit = 1'b0;

        if (!cache_on || cur_op != OP_READ) hist_d = H_NONE;
        else if (seq_hit)                   hist_d = H_KNOWN;
        else                                hist_d = H_LOOK;
    end

    AST_KNOWN_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_q == H_KNOWN) |-> $past(cache_on && cur_op == OP_READ)); // R6

    AST_NO_REUSE_WITHOUT_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_q == H_NONE) |-> !seq_hit); // R1
endmodule

// File: rtl/seqrd_decode.sv
module seqrd_decode
    import seqrd_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int WAY_W    = 2
) (
    input  logic                cache_on,
    input  op_e                 cur_op,
    input  logic                bank_odd,
    input  logic                cur_both,
    input  logic                seq_hit,
    input  logic [WAY_W-1:0]    seq_way,
    output logic [NUM_WAYS-1:0] tag_en,
    output logic [NUM_WAYS-1:0] data_en_even,
    output logic [NUM_WAYS-1:0] data_en_odd,
    output logic                reuse_hit
);
    logic [NUM_WAYS-1:0] way_mask;

    for (genvar gi = 0; gi < NUM_WAYS; gi++) begin : g_way
        assign way_mask[gi] = seq_hit ? (seq_way == WAY_W'(gi)) : 1'b1;
    end

    always_comb begin
        tag_en       = '0;
        data_en_even = '0;
        data_en_odd  = '0;
        reuse_hit    = 1'b0;
        if (cache_on) begin
            unique case (cur_op)
                OP_IDLE, OP_MAINT: begin
                    tag_en = '0;
                end
                OP_WRITE: begin
                    tag_en = '1;
                end
                OP_READ: begin
                    tag_en       = seq_hit ? '0 : '1;
                    data_en_even = (cur_both || !bank_odd) ? way_mask : '0;
                    data_en_odd  = (cur_both ||  bank_odd) ? way_mask : '0;
                    reuse_hit    = seq_hit;
                end
                default: tag_en = '0;
            endcase
        end
    end
endmodule

// File: rtl/seqrd_gate.sv
module seqrd_gate
    import seqrd_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NUM_WAYS   = 4,
    parameter int LINE_WORDS = 8,
    localparam int WAY_W     = $clog2(NUM_WAYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cache_on,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic                req_maint,
    input  logic                req_dword,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                hit_valid,
    input  logic [WAY_W-1:0]    hit_way,
    output logic                req_ready,
    output logic [ADDR_W-1:0]   acc_addr,
    output logic [NUM_WAYS-1:0] tag_en,
    output logic [NUM_WAYS-1:0] data_en_even,
    output logic [NUM_WAYS-1:0] data_en_odd,
    output logic                reuse_hit
);
    localparam int LINE_LSB = $clog2(LINE_WORDS) + 2;
    localparam int LINE_W   = ADDR_W - LINE_LSB;
    localparam logic [ADDR_W-3:0] WORD_ONE = {{(ADDR_W-3){1'b0}}, 1'b1};

    op_e               cur_op;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_both;
    phase_e            phase;
    logic              seq_hit;
    logic [WAY_W-1:0]  seq_way;

    seqrd_split #(.ADDR_W(ADDR_W)) u_split (
        .clk       (clk),
        .rst_n     (rst_n),
        .cache_on  (cache_on),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_maint (req_maint),
        .req_dword (req_dword),
        .req_addr  (req_addr),
        .cur_op    (cur_op),
        .cur_addr  (cur_addr),
        .cur_both  (cur_both),
        .req_ready (req_ready),
        .phase     (phase)
    );

    seqrd_hist #(.LINE_W(LINE_W), .WAY_W(WAY_W)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .cache_on  (cache_on),
        .cur_op    (cur_op),
        .cur_line  (cur_addr[ADDR_W-1:LINE_LSB]),
        .hit_valid (hit_valid),
        .hit_way   (hit_way),
        .seq_hit   (seq_hit),
        .seq_way   (seq_way)
    );

    seqrd_decode #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_decode (
        .cache_on     (cache_on),
        .cur_op       (cur_op),
        .bank_odd     (cur_addr[2]),
        .cur_both     (cur_both),
        .seq_hit      (seq_hit),
        .seq_way      (seq_way),
        .tag_en       (tag_en),
        .data_en_even (data_en_even),
        .data_en_odd  (data_en_odd),
        .reuse_hit    (reuse_hit)
    );

    assign acc_addr = cur_addr;

    AST_REUSE_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
        reuse_hit |-> ($countones(data_en_even | data_en_odd) == 1 && tag_en == '0)); // R2

    AST_REUSE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        reuse_hit |-> $past(|(data_en_even | data_en_odd))); // R3

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cache_on |-> (tag_en == '0 && data_en_even == '0 && data_en_odd == '0
                       && !reuse_hit && req_ready)); // R11

    AST_SINGLE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FIRST && req_valid && !req_write && !req_maint && !req_dword)
        |-> !((|data_en_even) && (|data_en_odd))); // R7

    AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FIRST && req_valid && req_write)
        |-> (data_en_even == '0 && data_en_odd == '0 && !reuse_hit)); // R6

    AST_SPLIT_NEXT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> (req_ready
                        && acc_addr[ADDR_W-1:2] == $past(acc_addr[ADDR_W-1:2]) + WORD_ONE)); // R9
endmodule

// File: tb/seqrd_gate_tb.sv
module seqrd_gate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cache_on = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_maint = 1'b0, req_dword = 1'b0;
    logic [31:0] req_addr = '0;
    logic        hit_valid = 1'b0;
    logic [1:0]  hit_way = '0;
    logic        req_ready, reuse_hit;
    logic [31:0] acc_addr;
    logic [3:0]  tag_en, data_en_even, data_en_odd;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [3:0]  tag, even, odd;
        logic        reuse, ready;
        logic [31:0] acc;
        string       name;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk; // 125 MHz

    seqrd_gate u_dut (
        .clk(clk), .rst_n(rst_n), .cache_on(cache_on),
        .req_valid(req_valid), .req_write(req_write), .req_maint(req_maint),
        .req_dword(req_dword), .req_addr(req_addr),
        .hit_valid(hit_valid), .hit_way(hit_way),
        .req_ready(req_ready), .acc_addr(acc_addr), .tag_en(tag_en),
        .data_en_even(data_en_even), .data_en_odd(data_en_odd), .reuse_hit(reuse_hit)
    );

    task automatic drive(input logic on, input logic v, input logic wr, input logic mt,
                         input logic dw, input logic [31:0] a, input logic hv,
                         input logic [1:0] hw, input logic [3:0] et, input logic [3:0] ee,
                         input logic [3:0] eo, input logic er, input logic erdy,
                         input logic [31:0] eacc, input string nm);
        exp_t e;
        cache_on = on; req_valid = v; req_write = wr; req_maint = mt;
        req_dword = dw; req_addr = a; hit_valid = hv; hit_way = hw;
        e.tag = et; e.even = ee; e.odd = eo; e.reuse = er; e.ready = erdy;
        e.acc = eacc; e.name = nm;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: sample 3 ns after the falling edge, before the next rising edge
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (tag_en !== e.tag || data_en_even !== e.even || data_en_odd !== e.odd ||
                    reuse_hit !== e.reuse || req_ready !== e.ready || acc_addr !== e.acc) begin
                    failures++;
                    $display("FAIL %s: got tag=%h even=%h odd=%h reuse=%b ready=%b acc=%h exp tag=%h even=%h odd=%h reuse=%b ready=%b acc=%h",
                             e.name, tag_en, data_en_even, data_en_odd, reuse_hit, req_ready,
                             acc_addr, e.tag, e.even, e.odd, e.reuse, e.ready, e.acc);
                end
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        //     on v wr mt dw addr      hv hw  tag   even  odd   ru rdy acc
        drive(1, 0, 0, 0, 0, 32'h000, 0, 0, 4'h0, 4'h0, 4'h0, 0, 1, 32'h000, "R12 idle after reset");
        drive(1, 1, 0, 0, 0, 32'h100, 0, 0, 4'hF, 4'hF, 4'h0, 0, 1, 32'h100, "R1 first read full lookup");
        drive(1, 1, 0, 0, 0, 32'h104, 1, 2, 4'h0, 4'h0, 4'h4, 1, 1, 32'h104, "R2 R7 reuse hit way2 odd bank");
        drive(1, 1, 0, 0, 0, 32'h108, 0, 0, 4'h0, 4'h4, 4'h0, 1, 1, 32'h108, "R3 stored way kept");
        drive(1, 1, 0, 0, 1, 32'h110, 0, 0, 4'h0, 4'h4, 4'h4, 1, 1, 32'h110, "R8 aligned dword both banks");
        drive(1, 1, 0, 0, 0, 32'h120, 0, 0, 4'hF, 4'hF, 4'h0, 0, 1, 32'h120, "R4 new line full lookup");
        drive(1, 1, 0, 0, 0, 32'h124, 0, 0, 4'hF, 4'h0, 4'hF, 0, 1, 32'h124, "R5 after miss full lookup");
        drive(1, 1, 0, 0, 0, 32'h128, 1, 1, 4'h0, 4'h2, 4'h0, 1, 1, 32'h128, "R2 reuse way1 even");
        drive(1, 0, 0, 0, 0, 32'h12C, 0, 0, 4'h0, 4'h0, 4'h0, 0, 1, 32'h12C, "R12 idle cycle");
        drive(1, 1, 0, 0, 0, 32'h12C, 1, 1, 4'hF, 4'h0, 4'hF, 0, 1, 32'h12C, "R6 idle clears history");
        drive(1, 1, 0, 0, 0, 32'h120, 1, 3, 4'h0, 4'h8, 4'h0, 1, 1, 32'h120, "R2 reuse way3");
        drive(1, 1, 1, 0, 0, 32'h124, 0, 0, 4'hF, 4'h0, 4'h0, 0, 1, 32'h124, "R6 write tags only");
        drive(1, 1, 0, 0, 0, 32'h128, 1, 3, 4'hF, 4'hF, 4'h0, 0, 1, 32'h128, "R6 write clears history");
        drive(1, 1, 1, 1, 0, 32'h128, 0, 0, 4'h0, 4'h0, 4'h0, 0, 1, 32'h128, "R6 maint enables nothing");
        drive(1, 1, 0, 0, 0, 32'h12C, 1, 1, 4'hF, 4'h0, 4'hF, 0, 1, 32'h12C, "R6 maint clears history");
        drive(1, 1, 0, 0, 1, 32'h14C, 1, 0, 4'hF, 4'h0, 4'hF, 0, 0, 32'h14C, "R9 split first half odd");
        drive(1, 1, 1, 0, 0, 32'h200, 1, 1, 4'h0, 4'h2, 4'h0, 1, 1, 32'h150, "R9 split second half even ignores inputs");
        drive(1, 1, 0, 0, 0, 32'h154, 0, 0, 4'h0, 4'h0, 4'h2, 1, 1, 32'h154, "R3 reuse after split");
        drive(1, 1, 0, 0, 1, 32'h15C, 0, 0, 4'h0, 4'h0, 4'h2, 1, 0, 32'h15C, "R10 split from word7 first half");
        drive(1, 1, 0, 0, 1, 32'h15C, 0, 0, 4'hF, 4'hF, 4'h0, 0, 1, 32'h160, "R10 second half next line full");
        drive(1, 1, 0, 0, 0, 32'h164, 1, 2, 4'h0, 4'h0, 4'h4, 1, 1, 32'h164, "R2 reuse in new line");
        drive(0, 1, 0, 0, 0, 32'h168, 1, 2, 4'h0, 4'h0, 4'h0, 0, 1, 32'h168, "R11 cache off quiet");
        drive(1, 1, 0, 0, 0, 32'h16C, 1, 2, 4'hF, 4'h0, 4'hF, 0, 1, 32'h16C, "R11 cache off clears history");
        drive(0, 1, 0, 0, 1, 32'h174, 0, 0, 4'h0, 4'h0, 4'h0, 0, 1, 32'h174, "R11 no split when off");
        drive(1, 1, 0, 0, 0, 32'h178, 0, 0, 4'hF, 4'hF, 4'h0, 0, 1, 32'h178, "R11 no pending half after off");
        drive(1, 0, 0, 0, 0, 32'h000, 0, 0, 4'h0, 4'h0, 4'h0, 0, 1, 32'h000, "R12 final idle");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule